// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block produces the bit-level waveforms of a single-wire (1-Wire) bus master. It runs from a free-running clock whose frequency is a parameter. Every bus interval is converted to a whole number of clock cycles when the block is elaborated. A host issues one operation at a time: a reset/presence cycle, a one-bit write, or a one-bit read. The block pulls the shared line low through an active-high drive enable. It never drives the line high. It watches the line through a synchronizer and reports a presence flag, a short flag and the bit that was read.

Commands enter over a valid/ready channel. `cmd_ready` is high only while the engine is idle. A command is taken in any cycle where `cmd_valid` and `cmd_ready` are both high. The opcode, the write bit and the speed are captured in that cycle. The host holds `cmd_valid` and the fields steady until it sees `cmd_ready`. A command that is waiting is not lost: it is accepted in the first idle cycle. Results have no back-pressure. `done` is a one-cycle pulse, and the three result flags are updated with it and then hold their values until the next `done`.

Top module: `ow_timing_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `ow_drive_low`, `done`, `presence`, `short_det` and `rd_bit` are all 0.
- R2: A command is accepted only in a cycle where `cmd_valid` and `cmd_ready` are both 1. Opcodes: `cmd_op` 2'b00 is reset, 2'b01 is write (`cmd_bit` gives the data), 2'b10 is read, and 2'b11 is also a write. `ow_drive_low` rises in the cycle after acceptance. `cmd_ready` stays 0 from then until the `done` cycle, and is 1 in the `done` cycle, so a held command starts at once.
- R3: A reset cycle pulls the line low for 600 µs (standard) or 72 µs (overdrive). It then releases the line and stays busy for a further 584 µs (standard) or 74 µs (overdrive).
- R4: In a reset cycle, the line is examined 70 µs (standard) or 7.5 µs (overdrive) after release. A low level there makes `presence` 1, and a high level makes it 0.
- R5: In a reset cycle, the line is examined 8 µs (standard) or 0.75 µs (overdrive) after release. A low level there makes `short_det` 1.
- R6: In a reset cycle, a low driven by a device at any point other than the two sample points has no effect on `presence`, `short_det` or the cycle length. This includes lows inside the masked span from 10 µs to 60 µs after release.
- R7: A write of 0 pulls the line low for 64 µs (standard) or 7.5 µs (overdrive). It then keeps the line released for a recovery of 5.3 µs (standard) or 3.0 µs (overdrive) before `done`.
- R8: A write of 1 pulls the line low for 6 µs (standard) or 1 µs (overdrive). The whole slot lasts 70 µs (standard) or 10 µs (overdrive).
- R9: A read pulls the line low for the same time as a write of 1 and lasts the same total time. `rd_bit` reports the line level 15 µs (standard) or 2 µs (overdrive) after the start of the slot.
- R10: The speed is taken from `speed_od` (1 means overdrive) in the acceptance cycle. Changes to it during an operation have no effect on that operation.
- R11: `done` is high for exactly one cycle per operation. The flags hold their values between `done` pulses. A non-reset operation reports `presence` and `short_det` as 0. A non-read operation reports `rd_bit` as 0.
- R12: Each duration equals the nearest whole number of clock cycles at `CLK_HZ`, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_od | input | 1 | 1 selects overdrive timing, sampled at acceptance |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; a command is taken when valid and ready are both 1 |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_bit | input | 1 | Data bit for a write |
| bus_in | input | 1 | Level seen on the bus line (asynchronous) |
| ow_drive_low | output | 1 | 1 pulls the line low; 0 releases it |
| done | output | 1 | One-cycle pulse when an operation completes |
| presence | output | 1 | A device answered the last reset |
| short_det | output | 1 | The line was low at the short sample of the last reset |
| rd_bit | output | 1 | Level read by the last read slot |

## Verification
The bench builds the engine with `CLK_HZ` set to 4 MHz and a two-stage synchronizer. At that rate a standard reset takes under 5000 cycles, so several full reset cycles fit in one run, and the 0.75 µs overdrive short sample still falls on a distinct cycle (cycle 3 after release). The rounding of the 5.3 µs recovery to 21 cycles exercises R12. The slave-pull windows are placed just around each sample point, which shows that the synchronizer delay is compensated to the cycle.

// File: rtl/ow_pkg.sv
`timescale 1ns/1ps
package ow_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_WRALT = 2'b11
  } ow_op_e;

  typedef struct packed {
    logic pres;
    logic shrt;
    logic rbit;
  } ow_res_t;

  // Interval lengths in nanoseconds, standard then overdrive.
  localparam int unsigned NS_RST_LOW_STD  = 600_000;
  localparam int unsigned NS_RST_LOW_OD   = 72_000;
  localparam int unsigned NS_RST_HIGH_STD = 584_000;
  localparam int unsigned NS_RST_HIGH_OD  = 74_000;
  localparam int unsigned NS_PRES_STD     = 70_000;
  localparam int unsigned NS_PRES_OD      = 7_500;
  localparam int unsigned NS_SHORT_STD    = 8_000;
  localparam int unsigned NS_SHORT_OD     = 750;
  localparam int unsigned NS_W0_LOW_STD   = 64_000;
  localparam int unsigned NS_W0_LOW_OD    = 7_500;
  localparam int unsigned NS_W0_REC_STD   = 5_300;
  localparam int unsigned NS_W0_REC_OD    = 3_000;
  localparam int unsigned NS_W1_LOW_STD   = 6_000;
  localparam int unsigned NS_W1_LOW_OD    = 1_000;
  localparam int unsigned NS_RD_SMP_STD   = 15_000;
  localparam int unsigned NS_RD_SMP_OD    = 2_000;
  localparam int unsigned NS_SLOT_STD     = 70_000;
  localparam int unsigned NS_SLOT_OD      = 10_000;

  // Nearest whole cycle count, never below one (R12).
  function automatic int unsigned ow_cyc(input int unsigned ns, input int unsigned hz);
    logic [63:0] prod;
    prod = (64'(ns) * 64'(hz) + 64'd500_000_000) / 64'd1_000_000_000;
    if (prod == 64'd0) prod = 64'd1;
    return 32'(prod);
  endfunction

endpackage

// File: rtl/ow_slot_plan.sv
`timescale 1ns/1ps
module ow_slot_plan
  import ow_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 17
) (
  input  logic [1:0]       op,
  input  logic             wbit,
  input  logic             od,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] tap_a,
  output logic [CNT_W-1:0] tap_b,
  output logic             chk_short,
  output logic             chk_pres,
  output logic             is_read
);
  localparam logic [CNT_W-1:0] SYNC_LAT = CNT_W'(SYNC_STAGES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] rst_low  [2];
  logic [CNT_W-1:0] rst_high [2];
  logic [CNT_W-1:0] pres_off [2];
  logic [CNT_W-1:0] short_off[2];
  logic [CNT_W-1:0] w0_low   [2];
  logic [CNT_W-1:0] w0_rec   [2];
  logic [CNT_W-1:0] w1_low   [2];
  logic [CNT_W-1:0] rd_off   [2];
  logic [CNT_W-1:0] slot_len [2];

  // One timing set per speed: index 0 standard, index 1 overdrive.
  for (genvar g = 0; g < 2; g++) begin : g_speed
    localparam bit FAST = (g == 1);
    assign rst_low[g]   = CNT_W'(ow_cyc(FAST ? NS_RST_LOW_OD  : NS_RST_LOW_STD,  CLK_HZ));
    assign rst_high[g]  = CNT_W'(ow_cyc(FAST ? NS_RST_HIGH_OD : NS_RST_HIGH_STD, CLK_HZ));
    assign pres_off[g]  = CNT_W'(ow_cyc(FAST ? NS_PRES_OD     : NS_PRES_STD,     CLK_HZ));
    assign short_off[g] = CNT_W'(ow_cyc(FAST ? NS_SHORT_OD    : NS_SHORT_STD,    CLK_HZ));
    assign w0_low[g]    = CNT_W'(ow_cyc(FAST ? NS_W0_LOW_OD   : NS_W0_LOW_STD,   CLK_HZ));
    assign w0_rec[g]    = CNT_W'(ow_cyc(FAST ? NS_W0_REC_OD   : NS_W0_REC_STD,   CLK_HZ));
    assign w1_low[g]    = CNT_W'(ow_cyc(FAST ? NS_W1_LOW_OD   : NS_W1_LOW_STD,   CLK_HZ));
    assign rd_off[g]    = CNT_W'(ow_cyc(FAST ? NS_RD_SMP_OD   : NS_RD_SMP_STD,   CLK_HZ));
    assign slot_len[g]  = CNT_W'(ow_cyc(FAST ? NS_SLOT_OD     : NS_SLOT_STD,     CLK_HZ));
  end

  // Sample taps are pushed later by the synchronizer latency so that the
  // captured level is the one present on the pin at the nominal instant.
  always_comb begin
    low_len   = w1_low[od];
    last_cnt  = slot_len[od] - ONE;
    tap_a     = '0;
    tap_b     = '0;
    chk_short = 1'b0;
    chk_pres  = 1'b0;
    is_read   = 1'b0;
    unique case (ow_op_e'(op))
      OP_RESET: begin
        low_len   = rst_low[od];
        last_cnt  = rst_low[od] + rst_high[od] - ONE;
        tap_a     = rst_low[od] + short_off[od] + SYNC_LAT;
        tap_b     = rst_low[od] + pres_off[od] + SYNC_LAT;
        chk_short = 1'b1;
        chk_pres  = 1'b1;
      end
      OP_READ: begin
        tap_a   = rd_off[od] + SYNC_LAT;
        is_read = 1'b1;
      end
      OP_WRITE, OP_WRALT: begin
        if (!wbit) begin
          low_len  = w0_low[od];
          last_cnt = w0_low[od] + w0_rec[od] - ONE;
        end
      end
    endcase
  end
endmodule

// File: rtl/ow_slot_seq.sv
`timescale 1ns/1ps
module ow_slot_seq #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] last_cnt,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             drive_low,
  output logic             finish,
  output logic             done
);
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] last_q;

  assign finish    = busy && (cnt == last_q);
  assign drive_low = busy && (cnt < low_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      low_q  <= '0;
      last_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        low_q  <= low_len;
        last_q <= last_cnt;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ow_bus_sampler.sv
`timescale 1ns/1ps
module ow_bus_sampler
  import ow_pkg::*;
#(
  parameter int unsigned CNT_W       = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_in,
  input  logic             start,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic             finish,
  input  logic [CNT_W-1:0] tap_a,
  input  logic [CNT_W-1:0] tap_b,
  input  logic             chk_short,
  input  logic             chk_pres,
  input  logic             is_read,
  output ow_res_t          res
);
  logic sync_q [SYNC_STAGES];
  logic bus_s;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= bus_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end
  assign bus_s = sync_q[SYNC_STAGES-1];

  logic [CNT_W-1:0] tap_a_q, tap_b_q;
  logic             short_en, pres_en, read_en;
  ow_res_t          cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_a_q  <= '0;
      tap_b_q  <= '0;
      short_en <= 1'b0;
      pres_en  <= 1'b0;
      read_en  <= 1'b0;
      cap      <= '0;
      res      <= '0;
    end else begin
      if (start) begin
        tap_a_q  <= tap_a;
        tap_b_q  <= tap_b;
        short_en <= chk_short;
        pres_en  <= chk_pres;
        read_en  <= is_read;
        cap      <= '0;
      end else if (busy) begin
        if (cnt == tap_a_q) begin
          if (short_en) cap.shrt <= !bus_s;
          if (read_en)  cap.rbit <= bus_s;
        end
        if (pres_en && cnt == tap_b_q) cap.pres <= !bus_s;
      end
      if (finish) res <= cap;
    end
  end
endmodule

// File: rtl/ow_timing_engine.sv
`timescale 1ns/1ps
module ow_timing_engine
  import ow_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_od,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       bus_in,
  output logic       ow_drive_low,
  output logic       done,
  output logic       presence,
  output logic       short_det,
  output logic       rd_bit
);
  localparam int unsigned LONGEST = ow_cyc(NS_RST_LOW_STD, CLK_HZ)
                                  + ow_cyc(NS_RST_HIGH_STD, CLK_HZ) + SYNC_STAGES + 4;
  localparam int unsigned CNT_W   = $clog2(LONGEST);

  logic [CNT_W-1:0] p_low, p_last, p_tap_a, p_tap_b;
  logic             p_short, p_pres, p_read;
  logic             busy, finish, accept;
  logic [CNT_W-1:0] cnt;
  ow_res_t          res;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  ow_slot_plan #(
    .CLK_HZ(CLK_HZ), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_plan (
    .op(cmd_op), .wbit(cmd_bit), .od(speed_od),
    .low_len(p_low), .last_cnt(p_last), .tap_a(p_tap_a), .tap_b(p_tap_b),
    .chk_short(p_short), .chk_pres(p_pres), .is_read(p_read)
  );

  ow_slot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .low_len(p_low), .last_cnt(p_last),
    .busy(busy), .cnt(cnt), .drive_low(ow_drive_low),
    .finish(finish), .done(done)
  );

  ow_bus_sampler #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .start(accept), .busy(busy), .cnt(cnt), .finish(finish),
    .tap_a(p_tap_a), .tap_b(p_tap_b),
    .chk_short(p_short), .chk_pres(p_pres), .is_read(p_read),
    .res(res)
  );

  assign presence  = res.pres;
  assign short_det = res.shrt;
  assign rd_bit    = res.rbit;
endmodule

// File: rtl/ow_engine_chk.sv
`timescale 1ns/1ps
module ow_engine_chk
  import ow_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic ow_drive_low,
  input logic done,
  input logic presence,
  input logic short_det,
  input logic rd_bit
);
  localparam int unsigned MAX_LOW = ow_cyc(NS_RST_LOW_STD, CLK_HZ);

  logic [31:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= '0;
    else if (ow_drive_low) low_run <= low_run + 32'd1;
    else                   low_run <= '0;
  end

  assert_drive_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ow_drive_low |-> !cmd_ready);

  assert_low_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> ow_drive_low);

  assert_ready_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_released_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ow_drive_low);

  assert_low_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ow_drive_low |-> (low_run < MAX_LOW));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({presence, short_det, rd_bit}));
endmodule

bind ow_timing_engine ow_engine_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ow_drive_low(ow_drive_low), .done(done), .presence(presence),
  .short_det(short_det), .rd_bit(rd_bit)
);

// File: tb/ow_timing_engine_bench.sv
`timescale 1ns/1ps
module ow_timing_engine_bench;
  localparam int unsigned HZ = 4_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_od = 1'b0, cmd_valid = 1'b0, cmd_bit = 1'b0, bus_in = 1'b1;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_ready, ow_drive_low, done, presence, short_det, rd_bit;

  always #2.5 clk = ~clk;

  ow_timing_engine #(.CLK_HZ(HZ), .SYNC_STAGES(2)) u_ow_timing_engine (
    .clk(clk), .rst_n(rst_n), .speed_od(speed_od), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit), .bus_in(bus_in),
    .ow_drive_low(ow_drive_low), .done(done), .presence(presence),
    .short_det(short_det), .rd_bit(rd_bit)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // stimulus
  logic tb_valid = 1'b0, tb_bit = 1'b0, tb_speed = 1'b0;
  logic [1:0] tb_op = 2'b00;
  int pull_from = -1, pull_to = -1;

  // behavioural reference: expected outputs for the current cycle
  bit m_busy = 0, m_drive = 0, m_ready = 1, m_done = 0, m_pres = 0, m_short = 0, m_rd = 0;
  int m_cnt = 0, m_low = 0, m_last = 0, m_pt_short = -1, m_pt_pres = -1, m_pt_rd = -1;
  bit c_pres = 0, c_short = 0, c_rd = 0;

  function automatic int us(real t);
    int c;
    c = int'($floor(t * real'(HZ) / 1.0e6 + 0.5));
    return (c < 1) ? 1 : c;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_accept();
    bit od;
    od = tb_speed;
    m_busy = 1; m_cnt = 0;
    c_pres = 0; c_short = 0; c_rd = 0;
    m_pt_short = -1; m_pt_pres = -1; m_pt_rd = -1;
    if (tb_op == 2'b00) begin
      m_low      = od ? us(72) : us(600);
      m_last     = m_low + (od ? us(74) : us(584)) - 1;
      m_pt_short = m_low + (od ? us(0.75) : us(8));
      m_pt_pres  = m_low + (od ? us(7.5) : us(70));
    end else if (tb_op == 2'b10) begin
      m_low   = od ? us(1) : us(6);
      m_last  = (od ? us(10) : us(70)) - 1;
      m_pt_rd = od ? us(2) : us(15);
    end else if (tb_bit) begin
      m_low  = od ? us(1) : us(6);
      m_last = (od ? us(10) : us(70)) - 1;
    end else begin
      m_low  = od ? us(7.5) : us(64);
      m_last = m_low + (od ? us(3.0) : us(5.3)) - 1;
    end
  endtask

  task automatic step();
    bit slave_low;
    @(negedge clk);
    checks++;
    if (ow_drive_low !== m_drive || cmd_ready !== m_ready || done !== m_done ||
        presence !== m_pres || short_det !== m_short || rd_bit !== m_rd) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s per-cycle drive,ready,done,pres,short,rd: actual %b%b%b%b%b%b expected %b%b%b%b%b%b",
                 cur_req, ow_drive_low, cmd_ready, done, presence, short_det, rd_bit,
                 m_drive, m_ready, m_done, m_pres, m_short, m_rd);
    end
    cmd_valid = tb_valid; cmd_op = tb_op; cmd_bit = tb_bit; speed_od = tb_speed;
    slave_low = m_busy && (m_cnt >= pull_from) && (m_cnt < pull_to);
    bus_in = !(m_drive || slave_low);
    m_done = 0;
    if (m_busy) begin
      if (m_cnt == m_pt_short) c_short = !bus_in;
      if (m_cnt == m_pt_pres)  c_pres  = !bus_in;
      if (m_cnt == m_pt_rd)    c_rd    = bus_in;
      if (m_cnt == m_last) begin
        m_busy = 0; m_done = 1;
        m_pres = c_pres; m_short = c_short; m_rd = c_rd;
      end else m_cnt++;
    end else if (tb_valid) model_accept();
    m_drive = m_busy && (m_cnt < m_low);
    m_ready = !m_busy;
  endtask

  task automatic run_cmd(input logic [1:0] op, input bit b, input bit od,
                         input int pf, input int pt, input bit flip, input bit keep,
                         input string req, input int exp_low, input int exp_busy,
                         input bit ep, input bit es, input bit er);
    int tot, lowc, rdy_bad;
    cur_req = req;
    tb_valid = 1; tb_op = op; tb_bit = b; tb_speed = od;
    pull_from = pf; pull_to = pt;
    while (!m_busy) step();
    if (!keep) tb_valid = 0;
    if (flip) tb_speed = !od;
    tot = 0; lowc = 0; rdy_bad = 0;
    do begin
      step();
      tot++;
      if (ow_drive_low) lowc++;
      if (!done && cmd_ready) rdy_bad++;
    end while (!done && tot < 20000);
    check(lowc == exp_low, req, "low cycles", lowc, exp_low);
    check(tot - 1 == exp_busy, req, "busy cycles", tot - 1, exp_busy);
    check(rdy_bad == 0, "R2", "ready while busy", rdy_bad, 0);
    check(presence == ep, req, "presence", presence, ep);
    check(short_det == es, req, "short_det", short_det, es);
    check(rd_bit == er, req, "rd_bit", rd_bit, er);
    if (!keep) begin
      step();
      check(done == 1'b0, "R11", "done width", done, 0);
    end
    pull_from = -1; pull_to = -1;
  endtask

  initial begin
    int lr, hr, lo, ho;
    lr = us(600); hr = us(584); lo = us(72); ho = us(74);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cmd_ready == 1 && ow_drive_low == 0 && done == 0, "R1", "idle outputs",
          {cmd_ready, ow_drive_low, done}, 3'b100);
    check({presence, short_det, rd_bit} == 3'b000, "R1", "flags",
          {presence, short_det, rd_bit}, 0);
    step();

    // R4: standard reset answered by a device
    run_cmd(2'b00, 0, 0, lr + us(20), lr + us(100), 0, 0, "R4", lr, lr + hr, 1, 0, 0);
    repeat (5) step();
    check(presence == 1, "R11", "presence holds while idle", presence, 1);
    // R5: line stuck low right after release
    run_cmd(2'b00, 0, 0, lr, lr + us(9), 0, 0, "R5", lr, lr + hr, 0, 1, 0);
    // R6: low confined to the masked span
    run_cmd(2'b00, 0, 0, lr + us(10), lr + us(60), 0, 0, "R6", lr, lr + hr, 0, 0, 0);
    // R3: overdrive reset with presence
    run_cmd(2'b00, 0, 1, lo + us(2), lo + us(20), 0, 0, "R3", lo, lo + ho, 1, 0, 0);
    run_cmd(2'b00, 0, 1, lo, lo + us(1), 0, 0, "R5", lo, lo + ho, 0, 1, 0);
    // R7: write 0, both speeds; alternate opcode at overdrive
    run_cmd(2'b01, 0, 0, -1, -1, 0, 0, "R7", us(64), us(64) + us(5.3), 0, 0, 0);
    run_cmd(2'b11, 0, 1, -1, -1, 0, 0, "R7", us(7.5), us(7.5) + us(3.0), 0, 0, 0);
    // R8: write 1; speed pin flipped mid-slot (R10)
    run_cmd(2'b01, 1, 0, -1, -1, 0, 0, "R8", us(6), us(70), 0, 0, 0);
    run_cmd(2'b01, 1, 1, -1, -1, 1, 0, "R10", us(1), us(10), 0, 0, 0);
    // R9: reads
    run_cmd(2'b10, 0, 0, us(6), us(30), 0, 0, "R9", us(6), us(70), 0, 0, 0);
    run_cmd(2'b10, 0, 0, -1, -1, 1, 0, "R10", us(6), us(70), 0, 0, 1);
    run_cmd(2'b10, 0, 1, us(1), us(5), 0, 1, "R9", us(1), us(10), 0, 0, 0);
    run_cmd(2'b10, 0, 1, -1, -1, 0, 0, "R2", us(1), us(10), 0, 0, 1);
    // R12: rounding of 5.3 us at 4 MHz gives 21 cycles
    check(us(5.3) == 21, "R12", "rounded recovery", us(5.3), 21);
    repeat (3) step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule